// File: doc/BRIEF.md
# Target Address Beat Compressor

This block sits in the target side of a bus interface and shortens the address sub-phase of each command/address transfer to the user logic. When a transaction is accepted it is told how many low address bits the decoding base address region spans. It then sends only the address beats needed to cover that span, lowest beat first. The beat width depends on the port mode: 32 bits in dual mode and 16 bits in quad mode.

A history register keeps the full address of the last finished phase. When the optional compare feature is on, the region needs every beat of the address, and the top beat of the new address equals the stored one, that top beat is dropped. This top beat is bits [63:32] in dual mode and bits [63:48] in quad mode. Each beat carries the number of beats in the phase and a last flag, so the downstream sequencer knows where the address sub-phase ends. Address decoding is done elsewhere.

Top module: `addr_beat_compressor`

## Requirements
- R1: After reset no beat is valid and the history register is empty. The first phase after reset therefore never drops its top beat.
- R2: The beat count is ceil(n/W). Here n is `region_bits` limited to the range 1..64 (0 counts as 1, values above 64 count as 64), and W is 32 when `quad_mode`=0 or 16 when `quad_mode`=1. This gives at most 2 or 4 beats.
- R3: Beat k carries address bits [k*W+W-1 : k*W], and beats go out in ascending k on consecutive cycles starting the cycle after `start` is accepted. In quad mode, `beat_data[31:16]` is zero.
- R4: Every beat shows the total beat count of its phase on `beat_cnt` and its own index on `beat_idx`. `beat_cnt` stays constant through the phase, and `beat_last` is 1 only on the final beat.
- R5: The top beat is dropped, giving one beat fewer, when all of these hold: `skip_en`=1, the history is valid, the count from R2 equals the mode's maximum, and the top-beat field of `addr` equals that field of the stored address.
- R6: With `skip_en`=0, no beat is ever dropped, even when the address matches.
- R7: When the region needs fewer beats than the mode's maximum, no beat is dropped, even when the upper field matches.
- R8: At the end of every phase, the history register takes the full 64-bit address of that phase, whether or not a beat was dropped.
- R9: A `start` that arrives while beats are being sent is ignored and does not disturb the running phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Pulse that begins a command/address phase (ignored while busy) |
| addr | input | 64 | Transaction address, sampled with `start` |
| region_bits | input | 7 | Number of low address bits spanned by the decoding region |
| quad_mode | input | 1 | 0: 32-bit beats, 1: 16-bit beats |
| skip_en | input | 1 | Enables upper-beat suppression on a history match |
| beat_valid | output | 1 | An address beat is present |
| beat_data | output | 32 | Address beat, right-aligned |
| beat_idx | output | 3 | Index of the current beat |
| beat_last | output | 1 | Final beat of the phase |
| beat_cnt | output | 3 | Number of beats in the current phase |

## Verification
The in-line assertions check, on every cycle, the following:
- the beat count stays steady inside a phase;
- the beat index rises by one per beat;
- a busy phase is not restarted;
- the count stays within the mode's range;
- the upper half of a quad beat is zero;
- the history turns valid after each final beat;
- a dropped beat always has valid history behind it.

The scoreboard scenarios show what no single-cycle property can:
- the exact address slices and their order;
- the drop decision across a sequence of phases, where the history written by one phase decides the next;
- the limits of the region size;
- the effect of the enable;
- the rejection of a `start` that arrives mid-phase.

// File: rtl/acu_pkg.sv
package acu_pkg;
  localparam int ACU_ADDR_W = 64;
  localparam int ACU_DUAL_W = 32;
  localparam int ACU_QUAD_W = 16;
  localparam int ACU_BITS_W = $clog2(ACU_ADDR_W + 1);
  localparam int ACU_CNT_W  = $clog2(ACU_ADDR_W / ACU_QUAD_W + 1);

  typedef enum logic {
    PORT_DUAL = 1'b0,
    PORT_QUAD = 1'b1
  } port_mode_e;
endpackage

// File: rtl/acu_reset_sync.sv
module acu_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/acu_beat_planner.sv
module acu_beat_planner #(
  parameter int ADDR_W = 64,
  parameter int DUAL_W = 32,
  parameter int QUAD_W = 16,
  parameter int BITS_W = 7,
  parameter int CNT_W  = 3
) (
  input  logic [BITS_W-1:0] region_bits,
  input  logic              quad_mode,
  input  logic              skip_en,
  input  logic              hold_valid,
  input  logic              upper_match,
  output logic [CNT_W-1:0]  beat_total,
  output logic              skip_upper
);
  localparam int DUAL_SH  = $clog2(DUAL_W);
  localparam int QUAD_SH  = $clog2(QUAD_W);
  localparam int DUAL_MAX = ADDR_W / DUAL_W;
  localparam int QUAD_MAX = ADDR_W / QUAD_W;
  localparam int SUM_W    = BITS_W + 1;

  logic [SUM_W-1:0] bits_c;
  logic [SUM_W-1:0] sum_dual;
  logic [SUM_W-1:0] sum_quad;
  logic [CNT_W-1:0] need_dual;
  logic [CNT_W-1:0] need_quad;
  logic [CNT_W-1:0] need_sel;
  logic [CNT_W-1:0] max_sel;
  logic             full_span;

  // clamp the region span into 1..ADDR_W
  always_comb begin
    bits_c = SUM_W'(region_bits);
    if (bits_c == '0)
      bits_c = SUM_W'(1);
    else if (bits_c > SUM_W'(ADDR_W))
      bits_c = SUM_W'(ADDR_W);
  end

  // ceil(bits / beat width) for both port widths
  always_comb begin
    sum_dual  = bits_c + SUM_W'(DUAL_W - 1);
    sum_quad  = bits_c + SUM_W'(QUAD_W - 1);
    need_dual = CNT_W'(sum_dual >> DUAL_SH);
    need_quad = CNT_W'(sum_quad >> QUAD_SH);
  end

  always_comb begin
    need_sel   = quad_mode ? need_quad : need_dual;
    max_sel    = quad_mode ? CNT_W'(QUAD_MAX) : CNT_W'(DUAL_MAX);
    full_span  = (need_sel == max_sel) && (max_sel > CNT_W'(1));
    skip_upper = skip_en && hold_valid && upper_match && full_span;
    beat_total = need_sel - CNT_W'(skip_upper);
  end

  // R2: a phase always has at least one beat and never more than the mode allows
  always_comb begin
    if (!$isunknown({region_bits, quad_mode, skip_en, hold_valid, upper_match})) begin
      a_r2_total_in_range: assert (beat_total >= CNT_W'(1) && beat_total <= max_sel)
        else $error("beat total out of range");
    end
  end
endmodule

// File: rtl/acu_history.sv
module acu_history #(
  parameter int ADDR_W = 64,
  parameter int DUAL_W = 32,
  parameter int QUAD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              commit,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              quad_mode,
  output logic              hold_valid,
  output logic              upper_match
);
  logic [ADDR_W-1:0] pend_q, pend_n;
  logic [ADDR_W-1:0] hold_q, hold_n;
  logic              valid_q, valid_n;
  logic              match_dual, match_quad;

  always_comb begin
    pend_n  = capture ? cur_addr : pend_q;
    hold_n  = commit  ? pend_q   : hold_q;
    valid_n = valid_q | commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_n;
    end
  end

  always_ff @(posedge clk) begin
    if (capture) pend_q <= pend_n;
    if (commit)  hold_q <= hold_n;
  end

  always_comb begin
    match_dual  = hold_q[ADDR_W-1 -: DUAL_W] == cur_addr[ADDR_W-1 -: DUAL_W];
    match_quad  = hold_q[ADDR_W-1 -: QUAD_W] == cur_addr[ADDR_W-1 -: QUAD_W];
    upper_match = quad_mode ? match_quad : match_dual;
  end

  assign hold_valid = valid_q;

  // R8: history becomes valid at the end of any phase and stays valid
  a_r8_valid_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> hold_valid)
    else $error("history not valid after commit");

  a_r1_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |=> hold_valid)
    else $error("history valid dropped without reset");
endmodule

// File: rtl/acu_serializer.sv
module acu_serializer #(
  parameter int ADDR_W = 64,
  parameter int DUAL_W = 32,
  parameter int QUAD_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_quad,
  input  logic [CNT_W-1:0]  load_total,
  output logic              beat_valid,
  output logic [DUAL_W-1:0] beat_data,
  output logic [CNT_W-1:0]  beat_idx,
  output logic              beat_last,
  output logic [CNT_W-1:0]  beat_cnt,
  output logic              phase_done
);
  localparam int QUAD_MAX = ADDR_W / QUAD_W;

  logic              valid_q, valid_n;
  logic [CNT_W-1:0]  idx_q, idx_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              quad_q, quad_n;
  logic [ADDR_W-1:0] sh_q, sh_n;
  logic              last_c;
  logic              adv;

  assign last_c = valid_q && (idx_q == cnt_q - CNT_W'(1));
  assign adv    = load || valid_q;

  always_comb begin
    valid_n = valid_q;
    idx_n   = idx_q;
    cnt_n   = cnt_q;
    quad_n  = quad_q;
    sh_n    = sh_q;
    if (load) begin
      valid_n = 1'b1;
      idx_n   = '0;
      cnt_n   = load_total;
      quad_n  = load_quad;
      sh_n    = load_addr;
    end else if (valid_q) begin
      if (last_c) begin
        valid_n = 1'b0;
      end else begin
        idx_n = idx_q + CNT_W'(1);
        sh_n  = quad_q ? (sh_q >> QUAD_W) : (sh_q >> DUAL_W);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
      quad_q  <= 1'b0;
    end else if (adv) begin
      valid_q <= valid_n;
      idx_q   <= idx_n;
      cnt_q   <= cnt_n;
      quad_q  <= quad_n;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) sh_q <= sh_n;
  end

  always_comb begin
    if (quad_q) beat_data = {{(DUAL_W-QUAD_W){1'b0}}, sh_q[QUAD_W-1:0]};
    else        beat_data = sh_q[DUAL_W-1:0];
  end

  assign beat_valid = valid_q;
  assign beat_idx   = idx_q;
  assign beat_cnt   = cnt_q;
  assign beat_last  = last_c;
  assign phase_done = last_c;

  // R4: count is held through the phase
  a_r4_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> (beat_valid && $stable(beat_cnt)))
    else $error("beat count changed inside a phase");

  // R9: a running phase is never restarted, the index climbs by one
  a_r9_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> (beat_idx == $past(beat_idx) + CNT_W'(1)))
    else $error("beat index did not advance by one");

  // R3: quad beats are zero above the 16-bit lane
  a_r3_quad_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && quad_q) |-> (beat_data[DUAL_W-1:QUAD_W] == '0))
    else $error("quad beat has bits above its lane");

  // R2: count within the limits of the mode
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_cnt >= CNT_W'(1) && beat_cnt <= CNT_W'(QUAD_MAX)))
    else $error("beat count outside limits");
endmodule

// File: rtl/addr_beat_compressor.sv
module addr_beat_compressor
  import acu_pkg::*;
#(
  parameter int ADDR_W = ACU_ADDR_W,
  parameter int DUAL_W = ACU_DUAL_W,
  parameter int QUAD_W = ACU_QUAD_W,
  parameter int BITS_W = $clog2(ADDR_W + 1),
  parameter int CNT_W  = $clog2(ADDR_W / QUAD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BITS_W-1:0] region_bits,
  input  logic              quad_mode,
  input  logic              skip_en,
  output logic              beat_valid,
  output logic [DUAL_W-1:0] beat_data,
  output logic [CNT_W-1:0]  beat_idx,
  output logic              beat_last,
  output logic [CNT_W-1:0]  beat_cnt
);
  logic             rst_sync_n;
  logic             accept;
  logic             hold_valid;
  logic             upper_match;
  logic             skip_upper;
  logic [CNT_W-1:0] beat_total;
  logic             phase_done;
  port_mode_e       mode_sel;

  assign mode_sel = port_mode_e'(quad_mode);
  assign accept   = start && !beat_valid;

  acu_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acu_history #(
    .ADDR_W (ADDR_W),
    .DUAL_W (DUAL_W),
    .QUAD_W (QUAD_W)
  ) u_hist (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .capture     (accept),
    .commit      (phase_done),
    .cur_addr    (addr),
    .quad_mode   (mode_sel == PORT_QUAD),
    .hold_valid  (hold_valid),
    .upper_match (upper_match)
  );

  acu_beat_planner #(
    .ADDR_W (ADDR_W),
    .DUAL_W (DUAL_W),
    .QUAD_W (QUAD_W),
    .BITS_W (BITS_W),
    .CNT_W  (CNT_W)
  ) u_plan (
    .region_bits (region_bits),
    .quad_mode   (mode_sel == PORT_QUAD),
    .skip_en     (skip_en),
    .hold_valid  (hold_valid),
    .upper_match (upper_match),
    .beat_total  (beat_total),
    .skip_upper  (skip_upper)
  );

  acu_serializer #(
    .ADDR_W (ADDR_W),
    .DUAL_W (DUAL_W),
    .QUAD_W (QUAD_W),
    .CNT_W  (CNT_W)
  ) u_ser (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (accept),
    .load_addr  (addr),
    .load_quad  (mode_sel == PORT_QUAD),
    .load_total (beat_total),
    .beat_valid (beat_valid),
    .beat_data  (beat_data),
    .beat_idx   (beat_idx),
    .beat_last  (beat_last),
    .beat_cnt   (beat_cnt),
    .phase_done (phase_done)
  );

  // R5/R1: a dropped beat only ever follows a recorded phase with the feature on
  a_r5_skip_needs_history: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (accept && skip_upper) |-> (hold_valid && skip_en))
    else $error("beat dropped without history or enable");

  // R8: history is valid once the final beat of a phase has left
  a_r8_history_after_last: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (beat_valid && beat_last) |=> hold_valid)
    else $error("history not recorded after phase");
endmodule

// File: tb/tb_addr_beat_compressor.sv
module tb_addr_beat_compressor;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [63:0] addr;
  logic [6:0]  region_bits;
  logic        quad_mode;
  logic        skip_en;
  logic        beat_valid;
  logic [31:0] beat_data;
  logic [2:0]  beat_idx;
  logic        beat_last;
  logic [2:0]  beat_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit mon_on = 0;

  typedef struct {
    logic [31:0] data;
    logic [2:0]  idx;
    logic        last;
    logic [2:0]  cnt;
    string       tag;
  } exp_beat_t;

  exp_beat_t exp_q[$];

  bit          m_hv;
  logic [63:0] m_hold;

  addr_beat_compressor dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .addr        (addr),
    .region_bits (region_bits),
    .quad_mode   (quad_mode),
    .skip_en     (skip_en),
    .beat_valid  (beat_valid),
    .beat_data   (beat_data),
    .beat_idx    (beat_idx),
    .beat_last   (beat_last),
    .beat_cnt    (beat_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // monitor: pops one expected item per observed beat
  always @(negedge clk) begin
    if (mon_on && beat_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL [R9] unexpected beat: data=%h idx=%0d cnt=%0d, expected no beat",
                 beat_data, beat_idx, beat_cnt);
      end else begin
        exp_beat_t e;
        e = exp_q.pop_front();
        if (beat_data !== e.data || beat_idx !== e.idx || beat_last !== e.last ||
            beat_cnt !== e.cnt) begin
          errors++;
          $display("FAIL [%s R3 R4] data=%h idx=%0d last=%0d cnt=%0d, expected data=%h idx=%0d last=%0d cnt=%0d",
                   e.tag, beat_data, beat_idx, beat_last, beat_cnt,
                   e.data, e.idx, e.last, e.cnt);
        end
      end
    end
  end

  // scoreboard model: predicts the beats of one phase and updates the history
  task automatic predict(input logic [63:0] a, input int bits, input bit q,
                         input bit en, input string tag);
    int w    = q ? 16 : 32;
    int maxb = 64 / w;
    int b    = (bits == 0) ? 1 : ((bits > 64) ? 64 : bits);
    int nb   = (b + w - 1) / w;
    bit up   = q ? (m_hold[63:48] == a[63:48]) : (m_hold[63:32] == a[63:32]);
    bit sk   = en && m_hv && (nb == maxb) && up;
    int n    = nb - (sk ? 1 : 0);
    for (int k = 0; k < n; k++) begin
      exp_beat_t e;
      logic [63:0] s;
      s      = a >> (k * w);
      e.data = q ? {16'h0, s[15:0]} : s[31:0];
      e.idx  = 3'(k);
      e.last = (k == n - 1);
      e.cnt  = 3'(n);
      e.tag  = tag;
      exp_q.push_back(e);
    end
    m_hv   = 1'b1;
    m_hold = a;
  endtask

  task automatic wait_idle();
    while (beat_valid) @(negedge clk);
  endtask

  task automatic issue(input logic [63:0] a, input int bits, input bit q,
                       input bit en, input string tag);
    predict(a, bits, q, en, tag);
    addr        = a;
    region_bits = 7'(bits);
    quad_mode   = q;
    skip_en     = en;
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  // a second start is raised while the phase is still sending
  task automatic issue_intrude(input logic [63:0] a, input logic [63:0] b2,
                               input int bits, input bit q, input string tag);
    predict(a, bits, q, 1'b0, tag);
    addr        = a;
    region_bits = 7'(bits);
    quad_mode   = q;
    skip_en     = 1'b0;
    start       = 1'b1;
    @(negedge clk);
    addr        = b2;
    region_bits = 7'd64;
    quad_mode   = ~q;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL [watchdog] run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; addr = '0; region_bits = '0;
    quad_mode = 1'b0; skip_en = 1'b0;
    m_hv = 1'b0; m_hold = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (beat_valid !== 1'b0) begin
      errors++;
      $display("FAIL [R1] beat_valid=%b during reset, expected 0", beat_valid);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (beat_valid !== 1'b0) begin
      errors++;
      $display("FAIL [R1] beat_valid=%b after reset, expected 0", beat_valid);
    end
    mon_on = 1'b1;

    // R1: first phase after reset sends all beats even with the feature on
    issue(64'hAABB_CCDD_1122_3344, 64, 1'b0, 1'b1, "R1");
    // R5: same upper half in dual mode, top beat dropped
    issue(64'hAABB_CCDD_5566_7788, 64, 1'b0, 1'b1, "R5");
    // R8: history took the address of the skipped phase, drop again
    issue(64'hAABB_CCDD_0000_0001, 64, 1'b0, 1'b1, "R8");
    // R8: upper differs from the newest history entry, full beats
    issue(64'h1234_5678_9ABC_DEF0, 64, 1'b0, 1'b1, "R8");
    // R2: narrow regions and clamping
    issue(64'h1234_5678_0000_00FF, 20, 1'b0, 1'b1, "R2");
    issue(64'h0F0F_0F0F_F0F0_F0F0, 0,  1'b0, 1'b1, "R2");
    issue(64'h0F0F_0F0F_F0F0_F0F0, 100, 1'b0, 1'b0, "R2");
    // R5: quad mode, upper 16 bits match history
    issue(64'h0F0F_2222_3333_4444, 64, 1'b1, 1'b1, "R5");
    // R7: region needs 3 quad beats, match ignored
    issue(64'h0F0F_9999_8888_7777, 40, 1'b1, 1'b1, "R7");
    issue(64'h0F0F_9999_8888_7777, 49, 1'b1, 1'b1, "R5");
    // R2: quad boundaries
    issue(64'h5555_6666_7777_8888, 16, 1'b1, 1'b1, "R2");
    issue(64'h5555_6666_7777_8888, 17, 1'b1, 1'b1, "R2");
    issue(64'h5555_6666_7777_8888, 33, 1'b1, 1'b1, "R2");
    // R6: feature off, match ignored
    issue(64'h5555_0000_1111_2222, 64, 1'b1, 1'b0, "R6");
    // R8: dual compare uses bits [63:32]; only [63:48] equal, no drop
    issue(64'h5555_ABCD_1111_2222, 64, 1'b0, 1'b1, "R8");
    // R9: start during a running phase is ignored
    issue_intrude(64'hDEAD_BEEF_CAFE_F00D, 64'h0101_0101_0101_0101, 64, 1'b1, "R9");
    // R9: history holds the running phase's address, not the intruder's
    issue(64'hDEAD_0000_0000_0002, 64, 1'b1, 1'b1, "R9");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL [R4] %0d expected beats never seen, expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule